// File: doc/BRIEF.md
# Dual-Form LFSR Period Meter

This block is a parameterised linear feedback shift register. Its feedback form can be chosen at run time: a many-to-one form, where one XOR reduction of the tapped stages feeds the first stage, or a one-to-many form, where the bit leaving the last stage is folded into each tapped stage input. A load strobe captures the seed, the form select and the tap mask together. After that the register advances on every clock that has `step_en` high. The current register value is always visible on `lfsr_state`.

Alongside the register, a small state machine counts the enabled steps from the load until the seed value comes back. The count reached at that point is the period of the chosen tap set. The same count can be compared with `max_period` (2^N−1) to show whether the taps are maximal-length. When a sequence can never return to its seed, the counter stops at 2^N and a no-return flag is raised. A register that sits at all zeros is flagged as locked.

The state machine has five named states:
- `ST_IDLE`: after reset, before any load. Nothing moves.
- `ST_RUN`: counting steps.
- `ST_FOUND`: the seed has come back, and the period is frozen.
- `ST_NORET`: the counter has saturated.
- `ST_LOCK`: a zero seed was loaded.

Its transitions are:
- `load` with a nonzero seed takes any state to `ST_RUN`.
- `load` with a zero seed takes any state to `ST_LOCK`.
- In `ST_RUN`, a step whose next value equals the seed moves to `ST_FOUND`.
- In `ST_RUN`, a step that brings the count to 2^N without a return moves to `ST_NORET`.
- The terminal states hold until the next load.

Top module: `lfsr_period_meter`

## Requirements
- R1: Reset behaviour. After reset, `lfsr_state` equals SEED_INIT (default 1), `period` is 0, and `done`, `no_return` and `locked` are all low. With no load, `step_en` does not move the register.
- R2: `max_period` equals 2^N−1, which is 15 for N=4.
- R3: Many-to-one form (`arch_sel`=0). The register shifts toward the MSB. The next value is {s[N-2:0], ^(s & taps)}.
- R4: One-to-many form (`arch_sel`=1). The register shifts toward the LSB. next[N-1] = s[0], and next[i] = s[i+1] ^ (taps[i] & s[0]) for i < N-1. Mask bit N-1 has no effect in this form.
- R5: One cycle after `load`, `lfsr_state` equals the seed and `period` is 0. When `load` and `step_en` are both high, `load` wins.
- R6: `arch_sel` and `tap_mask` are captured only at a load. Changing them between loads does not alter the sequence.
- R7: With `step_en` low and no load, `lfsr_state` and `period` hold their values.
- R8: After a nonzero-seed load, each enabled step adds one to `period`. On the step whose result equals the seed, `done` rises in the same cycle as the last increment. After that, `period` and `done` stay frozen until the next load, while the register keeps stepping.
- R9: If 2^N steps pass without a return to the seed, `period` stops at 2^N and `no_return` rises. `done` and `no_return` are never high together.
- R10: Loading a zero seed raises `locked` in the next cycle. `period` then stays 0, `done` never rises, and the register stays at zero.
- R11: After any load, `locked` is high exactly when `lfsr_state` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Captures seed, form select and tap mask; clears the period count |
| step_en | input | 1 | Advances the register by one step |
| arch_sel | input | 1 | 0 = many-to-one, 1 = one-to-many (captured at load) |
| tap_mask | input | N | One bit per stage enabling feedback (captured at load) |
| seed | input | N | Starting value (captured at load) |
| lfsr_state | output | N | Current register value |
| period | output | N+1 | Steps counted since load; frozen at the return to the seed or at 2^N |
| done | output | 1 | The seed has come back; `period` holds the cycle length |
| no_return | output | 1 | The counter saturated without a return |
| locked | output | 1 | The register holds all zeros after a load |
| max_period | output | N+1 | Constant 2^N−1 |

## Verification
Every result here is registered, so each one appears one clock edge after its cause. After a load, the seed, the zeroed count and, for a zero seed, `locked` all show after that edge. After each enabled step, the new state, the count, and `done` or `no_return` show after the stepping edge. The bench drives inputs on the falling edge and samples one time unit after the rising edge, checking every step against a software model. The sweep covers both forms, all 16 tap masks and two seeds, and the period the bench expects is found by iterating that model.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic {
        ARCH_MANY_TO_ONE = 1'b0,
        ARCH_ONE_TO_MANY = 1'b1
    } arch_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_FOUND = 3'd2,
        ST_NORET = 3'd3,
        ST_LOCK  = 3'd4
    } meter_st_e;

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step
    import lfsr_pkg::*;
#(
    parameter int N = 4
) (
    input  arch_e          arch,
    input  logic [N-1:0]   taps,
    input  logic [N-1:0]   cur,
    output logic [N-1:0]   nxt
);

    logic [N-1:0] ext_n;
    logic [N-1:0] int_n;
    logic         fb_ext;

    // single reduction over tapped stages
    assign fb_ext = ^(cur & taps);

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_ext_first
            assign ext_n[i] = fb_ext;
        end else begin : g_ext_shift
            assign ext_n[i] = cur[i-1];
        end

        if (i == N-1) begin : g_int_top
            assign int_n[i] = cur[0];
        end else begin : g_int_mid
            assign int_n[i] = cur[i+1] ^ (taps[i] & cur[0]);
        end
    end

    always_comb begin
        unique case (arch)
            ARCH_MANY_TO_ONE: nxt = ext_n;
            ARCH_ONE_TO_MANY: nxt = int_n;
            default:          nxt = ext_n;
        endcase
    end

endmodule

// File: rtl/lfsr_core.sv
module lfsr_core
    import lfsr_pkg::*;
#(
    parameter int N = 4,
    parameter logic [N-1:0] SEED_INIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          arch_sel,
    input  logic [N-1:0]  tap_mask,
    input  logic [N-1:0]  seed,
    output logic [N-1:0]  lfsr_q,
    output logic [N-1:0]  lfsr_nxt,
    output logic [N-1:0]  seed_q
);

    arch_e        arch_q;
    logic [N-1:0] taps_q;

    lfsr_step #(.N(N)) u_step (
        .arch (arch_q),
        .taps (taps_q),
        .cur  (lfsr_q),
        .nxt  (lfsr_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arch_q <= ARCH_MANY_TO_ONE;
            taps_q <= '0;
            seed_q <= SEED_INIT;
            lfsr_q <= SEED_INIT;
        end else if (load) begin
            arch_q <= arch_e'(arch_sel);
            taps_q <= tap_mask;
            seed_q <= seed;
            lfsr_q <= seed;
        end else if (adv) begin
            lfsr_q <= lfsr_nxt;
        end
    end

endmodule

// File: rtl/lfsr_period_fsm.sv
module lfsr_period_fsm
    import lfsr_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step_en,
    input  logic [N-1:0]  seed,
    input  logic [N-1:0]  seed_q,
    input  logic [N-1:0]  lfsr_q,
    input  logic [N-1:0]  lfsr_nxt,
    output logic [N:0]    period,
    output logic          active,
    output logic          done,
    output logic          no_return,
    output logic          locked
);

    localparam logic [N:0] CNT_FULL = {1'b1, {N{1'b0}}};
    localparam logic [N:0] CNT_LAST = CNT_FULL - 1'b1;

    meter_st_e  st_q, st_d;
    logic [N:0] cnt_q, cnt_d;

    // state and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (load) begin
            st_d  = (seed == '0) ? ST_LOCK : ST_RUN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_RUN: begin
                    if (step_en) begin
                        cnt_d = cnt_q + 1'b1;
                        if (lfsr_nxt == seed_q) begin
                            st_d = ST_FOUND;
                        end else if (cnt_q == CNT_LAST) begin
                            st_d = ST_NORET;
                        end
                    end
                end
                ST_FOUND: st_d = ST_FOUND;
                ST_NORET: st_d = ST_NORET;
                ST_LOCK:  st_d = ST_LOCK;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        period    = cnt_q;
        active    = 1'b0;
        done      = 1'b0;
        no_return = 1'b0;
        unique case (st_q)
            ST_IDLE:  active = 1'b0;
            ST_RUN:   active = 1'b1;
            ST_FOUND: begin active = 1'b1; done = 1'b1; end
            ST_NORET: begin active = 1'b1; no_return = 1'b1; end
            ST_LOCK:  active = 1'b1;
            default:  active = 1'b0;
        endcase
        locked = active && (lfsr_q == '0);
    end

endmodule

// File: rtl/lfsr_period_meter.sv
module lfsr_period_meter
    import lfsr_pkg::*;
#(
    parameter int N = 4,
    parameter logic [N-1:0] SEED_INIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step_en,
    input  logic          arch_sel,
    input  logic [N-1:0]  tap_mask,
    input  logic [N-1:0]  seed,
    output logic [N-1:0]  lfsr_state,
    output logic [N:0]    period,
    output logic          done,
    output logic          no_return,
    output logic          locked,
    output logic [N:0]    max_period
);

    localparam logic [N:0] MAX_LEN = {1'b0, {N{1'b1}}};

    logic [N-1:0] nxt_w;
    logic [N-1:0] seed_w;
    logic         active_w;

    lfsr_core #(.N(N), .SEED_INIT(SEED_INIT)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (step_en && active_w),
        .arch_sel (arch_sel),
        .tap_mask (tap_mask),
        .seed     (seed),
        .lfsr_q   (lfsr_state),
        .lfsr_nxt (nxt_w),
        .seed_q   (seed_w)
    );

    lfsr_period_fsm #(.N(N)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step_en   (step_en),
        .seed      (seed),
        .seed_q    (seed_w),
        .lfsr_q    (lfsr_state),
        .lfsr_nxt  (nxt_w),
        .period    (period),
        .active    (active_w),
        .done      (done),
        .no_return (no_return),
        .locked    (locked)
    );

    assign max_period = MAX_LEN;

endmodule

// File: rtl/lfsr_period_chk.sv
module lfsr_period_chk #(
    parameter int N = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          step_en,
    input logic [N-1:0]  seed,
    input logic [N-1:0]  lfsr_state,
    input logic [N:0]    period,
    input logic          done,
    input logic          no_return,
    input logic          locked
);

    localparam logic [N:0] CNT_FULL = {1'b1, {N{1'b0}}};

    // R5
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (lfsr_state == $past(seed)) && (period == '0));

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(lfsr_state) && $stable(period));

    // R8
    done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done && $stable(period));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period <= CNT_FULL);

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && no_return));

    // R10
    zero_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0) |=> locked && !done && (period == '0));

endmodule

bind lfsr_period_meter lfsr_period_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step_en    (step_en),
    .seed       (seed),
    .lfsr_state (lfsr_state),
    .period     (period),
    .done       (done),
    .no_return  (no_return),
    .locked     (locked)
);

// File: tb/tb_lfsr_period_meter.sv
module tb_lfsr_period_meter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         step_en = 1'b0;
    logic         arch_sel = 1'b0;
    logic [N-1:0] tap_mask = '0;
    logic [N-1:0] seed = '0;
    logic [N-1:0] lfsr_state;
    logic [N:0]   period;
    logic         done, no_return, locked;
    logic [N:0]   max_period;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lfsr_period_meter #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .step_en(step_en),
        .arch_sel(arch_sel), .tap_mask(tap_mask), .seed(seed),
        .lfsr_state(lfsr_state), .period(period), .done(done),
        .no_return(no_return), .locked(locked), .max_period(max_period)
    );

    function automatic logic [3:0] model_next(input logic a, input logic [3:0] t, input logic [3:0] s);
        logic [3:0] r;
        if (!a) begin
            r = {s[2:0], ^(s & t)};
        end else begin
            r[3] = s[0];
            r[2] = s[3] ^ (t[2] & s[0]);
            r[1] = s[2] ^ (t[1] & s[0]);
            r[0] = s[1] ^ (t[0] & s[0]);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive on falling edge, sample just after rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic a, input logic [3:0] t, input logic [3:0] s, input logic st);
        @(negedge clk);
        arch_sel = a; tap_mask = t; seed = s; load = 1'b1; step_en = st;
        tick();
        @(negedge clk);
        load = 1'b0; step_en = 1'b0;
    endtask

    // run 2^N+1 steps comparing state, count and flags against the model
    task automatic sweep_one(input logic a, input logic [3:0] t, input logic [3:0] s);
        logic [3:0] m;
        int exp_cnt;
        bit fin, ret;
        do_load(a, t, s, 1'b0);
        check("R5 seed loaded", {lfsr_state, period}, {s, 5'd0});
        m = s; exp_cnt = 0; fin = 0; ret = 0;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            step_en = 1'b1;
            tick();
            m = model_next(a, t, m);
            if (!fin) begin
                exp_cnt = k;
                if (m == s) begin fin = 1; ret = 1; end
                else if (k == 16) fin = 1;
            end
            check(a ? "R4 one-to-many state" : "R3 many-to-one state", lfsr_state, m);
            check("R8 R9 count and flags", {period, done, no_return},
                  {exp_cnt[4:0], fin && ret, fin && !ret});
            check("R11 lock flag", locked, m == 4'd0);
        end
        @(negedge clk);
        step_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 reset", {lfsr_state, period, done, no_return, locked}, {4'd1, 5'd0, 3'b000});
        // R2
        check("R2 max period", max_period, 5'd15);
        // R1 steps before any load do nothing
        @(negedge clk);
        step_en = 1'b1;
        tick(); tick();
        check("R1 idle hold", {lfsr_state, period}, {4'd1, 5'd0});
        @(negedge clk);
        step_en = 1'b0;

        // sweep: both forms, every mask, two seeds
        for (int a = 0; a < 2; a++)
            for (int t = 0; t < 16; t++) begin
                sweep_one(a[0], t[3:0], 4'h1);
                sweep_one(a[0], t[3:0], 4'h6);
            end

        // R5 load wins over step
        do_load(1'b0, 4'h9, 4'h5, 1'b1);
        check("R5 load priority", {lfsr_state, period}, {4'h5, 5'd0});

        // R7 hold with step_en low
        @(negedge clk); step_en = 1'b1; tick();
        @(negedge clk); step_en = 1'b0;
        m = model_next(1'b0, 4'h9, 4'h5);
        tick(); tick(); tick();
        check("R7 hold", {lfsr_state, period}, {m, 5'd1});

        // R6 config captured only at load
        do_load(1'b1, 4'h3, 4'h1, 1'b0);
        @(negedge clk);
        arch_sel = 1'b0; tap_mask = 4'h0;
        m = 4'h1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); step_en = 1'b1; tick();
            m = model_next(1'b1, 4'h3, m);
            check("R6 config latched", lfsr_state, m);
        end
        @(negedge clk); step_en = 1'b0;

        // R10 zero seed
        do_load(1'b0, 4'h9, 4'h0, 1'b0);
        check("R10 locked at once", {locked, done, period}, {2'b10, 5'd0});
        @(negedge clk); step_en = 1'b1;
        repeat (20) tick();
        check("R10 stays locked", {lfsr_state, locked, done, no_return, period}, {4'h0, 3'b100, 5'd0});
        @(negedge clk); step_en = 1'b0;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule